// File: doc/BRIEF.md
# Smart Card Character Serializer with Convention Control

This block moves single characters between a host register interface and the one-wire serial line of a smart card link. The host writes a byte into a transmit data register. The block then sends a frame on `ser_tx`: a low start bit, eight data bits, one even parity bit, and a high idle bit. In the other direction the receiver watches `ser_rx` for a falling edge and checks that the start bit is still low at the middle of its bit time. It then samples each later bit at its middle, checks parity, and places the byte in a receive data register.

A mode register decides how bytes map onto the line. It selects the bit order (least or most significant bit first) and whether data is inverted. Together these let one block serve cards that use either the direct or the inverse convention. Both controls act on transmit and receive alike. Parity is always taken over the eight bits exactly as they appear on the line, so inversion never changes the parity bit. A standby input returns the mode register to its reset value. Each bit lasts `CLKS_PER_BIT` clock cycles, fixed at build time.

Top module: `sc_char_port`

## Requirements
- R1: Mode register bit 3 selects the bit order. When it is 0, data bit 0 is the first data bit on the line in both directions. When it is 1, data bit 7 goes first in both directions.
- R2: Mode register bit 2 selects inversion. When it is 1, every data bit is complemented on its way to the line, and every received data bit is complemented before it is stored.
- R3: The parity bit follows the eight data bits. It equals the XOR of those eight bits as they appear on the line, which gives even parity. Inversion does not change this rule.
- R4: After reset the mode register (address 0) reads 0xF2. Bits 7 to 4 and bit 1 always read 1, and writes to them have no effect. Bit 0 is the enable, and bits 3, 2 and 0 are writable.
- R5: While `standby` is high at a clock edge, the mode register returns to 0xF2.
- R6: A transmit frame is one low start bit, eight data bits, the parity bit, and then one high bit. Each of these bits lasts `CLKS_PER_BIT` cycles. `ser_tx` is high whenever no frame is in progress.
- R7: The receiver runs only when the enable bit is 1. It starts on a falling edge of `ser_rx` and drops the event if the line is high at the middle of the start bit. It samples each later bit at its middle. After the parity bit it stores the byte and sets the receive-full flag. Reading address 2 returns the byte and clears that flag.
- R8: A received parity bit that does not match the received line bits sets a sticky parity-error flag. Writing the status register with bit 2 set clears the flag.
- R9: The transmit-empty flag is 1 after reset. Writing address 1 while the enable bit is 1 loads the byte and clears the flag, and the flag returns to 1 when the frame starts. A write to address 1 while the enable bit is 0 is ignored: the flag stays 1 and no frame is sent.
- R10: Register map: address 0 is the mode register, address 1 is transmit data (write), address 2 is receive data (read), and address 3 is status. Status bit 0 is transmit-empty, bit 1 is receive-full, bit 2 is parity-error, and the other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Low-power request; returns the mode register to its default |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ser_tx | output | 1 | Serial transmit line, idle high |
| ser_rx | input | 1 | Serial receive line, idle high |

## Verification
The assertions assume that `ser_rx` stays high when idle and that each frame on it is followed by high time before the next start bit. The stimulus meets this in every case. Loopback frames end with the transmitter's own idle bit. Hand-driven frames hold the line high for two bit times after the parity bit, and the one deliberate short low pulse is much shorter than half a bit. The assertions also assume that the host does not change the mode register while a frame is moving. The bench writes the mode register only when both directions are idle.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
    localparam int DW      = 8;
    localparam int FRAME_W = DW + 3;

    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_TDR  = 2'd1;
    localparam logic [1:0] A_RDR  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    localparam logic [7:0] MODE_DEFAULT = 8'hF2;

    typedef struct packed {
        logic msb_first;
        logic invert;
        logic enable;
    } mode_t;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

    // Map between a stored byte and its line order. Reversal and complement
    // are both involutions and commute, so the same map serves both directions.
    function automatic logic [DW-1:0] conv_byte(input logic [DW-1:0] d, input mode_t m);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = m.msb_first ? d[DW-1-i] : d[i];
        return m.invert ? ~r : r;
    endfunction

    function automatic logic even_par(input logic [DW-1:0] d);
        return ^d;
    endfunction
endpackage

// File: rtl/sc_mode_reg.sv
`timescale 1ns/1ps
module sc_mode_reg
    import sc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       standby,
    input  logic       wr,
    input  mode_t      wmode,
    output mode_t      mode,
    output logic [7:0] mode_rd
);
    mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst || standby) mode_q <= '0;
        else if (wr)        mode_q <= wmode;
    end

    assign mode    = mode_q;
    assign mode_rd = {4'hF, mode_q.msb_first, mode_q.invert, 1'b1, mode_q.enable};

    AST_STANDBY_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        standby |=> (mode_rd == MODE_DEFAULT)); // R5
endmodule

// File: rtl/sc_tx.sv
`timescale 1ns/1ps
module sc_tx
    import sc_pkg::*;
#(
    parameter int CLKS_PER_BIT = 372
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_t         mode,
    input  logic          tdr_wr,
    input  logic [DW-1:0] wdata,
    output logic          tx_empty,
    output logic          ser_tx
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int IW = $clog2(FRAME_W + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_W - 1);

    logic [DW-1:0]      tdr_q;
    logic               empty_q;
    logic               busy_q;
    logic [FRAME_W-1:0] sh_q;
    logic [CW-1:0]      cnt_q;
    logic [IW-1:0]      idx_q;

    logic [DW-1:0]      line_w;
    logic [FRAME_W-1:0] frame_w;
    logic               load;
    logic               wr_ok;

    always_comb begin
        line_w  = conv_byte(tdr_q, mode);
        frame_w = {1'b1, even_par(line_w), line_w, 1'b0};
        load    = !busy_q && !empty_q;
        wr_ok   = tdr_wr && mode.enable;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tdr_q   <= '0;
            empty_q <= 1'b1;
            busy_q  <= 1'b0;
            sh_q    <= '1;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            if (load) begin
                sh_q    <= frame_w;
                busy_q  <= 1'b1;
                cnt_q   <= '0;
                idx_q   <= '0;
                empty_q <= 1'b1;
            end else if (busy_q) begin
                if (cnt_q == CNT_LAST) begin
                    cnt_q <= '0;
                    sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
                    if (idx_q == IDX_LAST) busy_q <= 1'b0;
                    else                   idx_q  <= idx_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (wr_ok) begin
                tdr_q   <= wdata;
                empty_q <= 1'b0;
            end
        end
    end

    assign tx_empty = empty_q;
    assign ser_tx   = busy_q ? sh_q[0] : 1'b1;

    AST_TX_DISABLED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (tdr_wr && !mode.enable && empty_q) |=> empty_q); // R9
    AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !empty_q && !wr_ok) |=> (busy_q && empty_q)); // R9
    AST_TX_FRAME_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> !ser_tx); // R6
    AST_TX_PARITY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> (sh_q[DW+1] == ^sh_q[DW:1])); // R3
endmodule

// File: rtl/sc_rx.sv
`timescale 1ns/1ps
module sc_rx
    import sc_pkg::*;
#(
    parameter int CLKS_PER_BIT = 372
) (
    input  logic          clk,
    input  logic          rst,
    input  mode_t         mode,
    input  logic          ser_rx,
    input  logic          rd_clr,
    input  logic          perr_clr,
    output logic [DW-1:0] rdr,
    output logic          rx_full,
    output logic          perr
);
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] CNT_LAST  = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(CLKS_PER_BIT / 2 - 1);
    localparam logic [3:0]    IDX_PAR   = 4'(DW);

    logic       s1_q, s2_q, s3_q;
    rx_state_e  st_q;
    logic [CW-1:0] cnt_q;
    logic [3:0]    idx_q;
    logic [DW:0]   sh_q;
    logic [DW-1:0] rdr_q;
    logic          full_q;
    logic          perr_q;

    logic [DW:0]   nxt;
    logic          store;
    logic          bad_par;

    always_comb begin
        nxt     = {s2_q, sh_q[DW:1]};
        store   = (st_q == RX_BITS) && (cnt_q == CNT_LAST) && (idx_q == IDX_PAR);
        bad_par = even_par(nxt[DW-1:0]) != nxt[DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            s3_q   <= 1'b1;
            st_q   <= RX_IDLE;
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            rdr_q  <= '0;
            full_q <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            s1_q <= ser_rx;
            s2_q <= s1_q;
            s3_q <= s2_q;
            case (st_q)
                RX_IDLE: begin
                    if (mode.enable && s3_q && !s2_q) begin
                        st_q  <= RX_START;
                        cnt_q <= '0;
                    end
                end
                RX_START: begin
                    if (cnt_q == HALF_LAST) begin
                        cnt_q <= '0;
                        idx_q <= '0;
                        st_q  <= s2_q ? RX_IDLE : RX_BITS;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (cnt_q == CNT_LAST) begin
                        cnt_q <= '0;
                        sh_q  <= nxt;
                        if (idx_q == IDX_PAR) st_q  <= RX_IDLE;
                        else                  idx_q <= idx_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= RX_IDLE;
            endcase

            if (store) begin
                rdr_q  <= conv_byte(nxt[DW-1:0], mode);
                full_q <= 1'b1;
            end else if (rd_clr) begin
                full_q <= 1'b0;
            end

            if (store && bad_par) perr_q <= 1'b1;
            else if (perr_clr)    perr_q <= 1'b0;
        end
    end

    assign rdr     = rdr_q;
    assign rx_full = full_q;
    assign perr    = perr_q;

    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (perr_q && !perr_clr) |=> perr_q); // R8
    AST_RXFULL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !store) |=> !full_q); // R7
    AST_RX_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_BITS) |-> (idx_q <= IDX_PAR)); // R7
    AST_RX_IDLE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_IDLE && !mode.enable) |=> (st_q == RX_IDLE)); // R7
endmodule

// File: rtl/sc_char_port.sv
`timescale 1ns/1ps
module sc_char_port
    import sc_pkg::*;
#(
    parameter int CLKS_PER_BIT = 372
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       standby,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       ser_tx,
    input  logic       ser_rx
);
    mode_t       mode;
    mode_t       wmode;
    logic [7:0]  mode_rd;
    logic [7:0]  rdr;
    logic        tx_empty, rx_full, perr;
    logic        mode_wr, tdr_wr, rd_clr, perr_clr;

    always_comb begin
        wmode    = '{msb_first: wdata[3], invert: wdata[2], enable: wdata[0]};
        mode_wr  = wr_en && (addr == A_MODE);
        tdr_wr   = wr_en && (addr == A_TDR);
        rd_clr   = rd_en && (addr == A_RDR);
        perr_clr = wr_en && (addr == A_STAT) && wdata[2];
    end

    sc_mode_reg u_mode (
        .clk(clk), .rst(rst), .standby(standby), .wr(mode_wr),
        .wmode(wmode), .mode(mode), .mode_rd(mode_rd)
    );

    sc_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst(rst), .mode(mode), .tdr_wr(tdr_wr),
        .wdata(wdata), .tx_empty(tx_empty), .ser_tx(ser_tx)
    );

    sc_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst(rst), .mode(mode), .ser_rx(ser_rx),
        .rd_clr(rd_clr), .perr_clr(perr_clr),
        .rdr(rdr), .rx_full(rx_full), .perr(perr)
    );

    always_comb begin
        case (addr)
            A_MODE:  rdata = mode_rd;
            A_RDR:   rdata = rdr;
            A_STAT:  rdata = {5'b0, perr, rx_full, tx_empty};
            default: rdata = 8'h00;
        endcase
    end

    AST_RESET_STATUS: assert property (@(posedge clk)
        rst |=> (tx_empty && !rx_full && !perr && ser_tx)); // R9
endmodule

// File: tb/sim_sc_char_port.sv
`timescale 1ns/1ps
module sim_sc_char_port;
    localparam int C = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       standby = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ser_tx;
    logic       use_loop = 1'b1;
    logic       rx_drv = 1'b1;
    logic       ser_rx;

    int n_chk = 0;
    int n_bad = 0;

    assign ser_rx = use_loop ? ser_tx : rx_drv;

    always #10 clk = ~clk;

    sc_char_port #(.CLKS_PER_BIT(C)) u0 (
        .clk(clk), .rst(rst), .standby(standby), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ser_tx(ser_tx), .ser_rx(ser_rx)
    );

    // {order, invert, data, expected line bits (bit i = i-th data bit on the line)}
    localparam logic [17:0] VEC [8] = '{
        {1'b0, 1'b0, 8'h3B, 8'h3B},
        {1'b1, 1'b0, 8'h3B, 8'hDC},
        {1'b0, 1'b1, 8'h3B, 8'hC4},
        {1'b1, 1'b1, 8'h3B, 8'h23},
        {1'b0, 1'b0, 8'h80, 8'h80},
        {1'b1, 1'b0, 8'h01, 8'h80},
        {1'b1, 1'b1, 8'hF0, 8'hF0},
        {1'b0, 1'b1, 8'h00, 8'hFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_full(output logic ok);
        logic [7:0] s;
        ok = 1'b0;
        for (int i = 0; i < 30 * C; i++) begin
            rd(2'd3, s);
            if (s[1]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic drive_frame(input logic [7:0] line, input logic par);
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (C) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_drv = line[i];
            repeat (C) @(negedge clk);
        end
        rx_drv = par;
        repeat (C) @(negedge clk);
        rx_drv = 1'b1;
        repeat (2 * C) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] line;
        logic       ok;
        logic       low_seen;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        rd(2'd0, d); chk("R4 mode after reset", d, 8'hF2);
        rd(2'd3, d); chk("R9 R10 status after reset", d, 8'h01);
        chk("R6 line idle after reset", ser_tx, 1'b1);

        // Reserved bits
        wr(2'd0, 8'h00); rd(2'd0, d); chk("R4 write zeros", d, 8'hF2);
        wr(2'd0, 8'hFF); rd(2'd0, d); chk("R4 write ones", d, 8'hFF);

        // Vector table, loopback
        use_loop = 1'b1;
        for (int v = 0; v < 8; v++) begin
            wr(2'd0, {4'h0, VEC[v][17], VEC[v][16], 1'b0, 1'b1});
            wr(2'd1, VEC[v][15:8]);
            @(negedge ser_tx);
            repeat (C / 2) @(negedge clk);
            chk("R6 start bit low", ser_tx, 1'b0);
            for (int i = 0; i < 8; i++) begin
                repeat (C) @(negedge clk);
                line[i] = ser_tx;
            end
            chk("R1 R2 line data order and level", line, VEC[v][7:0]);
            repeat (C) @(negedge clk);
            chk("R3 parity bit", ser_tx, ^VEC[v][7:0]);
            repeat (C) @(negedge clk);
            chk("R6 idle bit high", ser_tx, 1'b1);
            wait_full(ok);
            chk("R7 rx full after loopback", ok, 1'b1);
            rd(2'd2, d); chk("R1 R2 R7 loopback byte", d, VEC[v][15:8]);
            rd(2'd3, d); chk("R7 R8 status after read", d, 8'h01);
        end

        // Write with smart card mode disabled
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hA5);
        rd(2'd3, d); chk("R9 tx empty kept when disabled", d[0], 1'b1);
        wr(2'd0, 8'h01);
        low_seen = 1'b0;
        for (int i = 0; i < 3 * C; i++) begin
            @(negedge clk);
            if (!ser_tx) low_seen = 1'b1;
        end
        chk("R9 no frame from disabled write", low_seen, 1'b0);

        // Hand-driven receive
        use_loop = 1'b0;
        rx_drv = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h0D);
        drive_frame(8'h23, 1'b1);
        wait_full(ok);
        rd(2'd2, d); chk("R1 R2 R3 inverse convention receive", d, 8'h3B);
        rd(2'd3, d); chk("R3 no parity error with inversion", d[2], 1'b0);

        wr(2'd0, 8'h01);
        drive_frame(8'h55, 1'b1);
        wait_full(ok);
        rd(2'd2, d); chk("R7 byte with bad parity", d, 8'h55);
        rd(2'd3, d); chk("R8 parity error set", d, 8'h05);
        drive_frame(8'h0F, 1'b0);
        wait_full(ok);
        rd(2'd2, d); chk("R7 second byte", d, 8'h0F);
        rd(2'd3, d); chk("R8 parity error sticky", d[2], 1'b1);
        wr(2'd3, 8'h04);
        rd(2'd3, d); chk("R8 parity error cleared", d, 8'h01);

        // Short low pulse is not a start bit
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (C / 4) @(negedge clk);
        rx_drv = 1'b1;
        repeat (12 * C) @(negedge clk);
        rd(2'd3, d); chk("R7 glitch rejected", d[1], 1'b0);

        // Receiver disabled
        wr(2'd0, 8'h00);
        drive_frame(8'h5A, 1'b0);
        rd(2'd3, d); chk("R7 receiver idle when disabled", d[1], 1'b0);

        // Standby
        wr(2'd0, 8'h0D);
        rd(2'd0, d); chk("R4 mode written", d, 8'hFF);
        @(negedge clk); standby = 1'b1;
        @(negedge clk); standby = 1'b0;
        rd(2'd0, d); chk("R5 standby restores default", d, 8'hF2);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule